// File: doc/BRIEF.md
# Chunked Cross-Clock Byte Ring

This block moves a byte stream from a producer clock domain into an unrelated consumer clock domain. Its storage is a ring of eight equal asynchronous FIFOs of 512 bytes each, 4096 bytes in all. The producer fills the FIFOs one after another. The consumer reads faster than the producer writes, so it does not poll byte by byte. It waits for a chunk-ready flag, which marks one full half of the ring (four FIFOs, 2048 bytes). It then drains that half and waits for the other half.

Each FIFO keeps Gray-coded pointers that cross between the domains through two-flop synchronizers. Full and empty are derived in each domain from the synchronized copy of the other side's pointer. Two small state machines steer the ring. The write machine has the states W_FILL and W_BLOCKED:

- W_FILL to W_FILL: the current FIFO fills and the next FIFO is already empty.
- W_FILL to W_BLOCKED: the current FIFO fills and the next FIFO still holds data.
- W_BLOCKED to W_FILL: the selected FIFO has been seen empty.

The read machine has the states R_WAIT and R_DRAIN:

- R_WAIT to R_DRAIN: the first byte of a ready half is taken.
- R_DRAIN to R_DRAIN: a FIFO inside the half runs empty and the reader moves to the next FIFO.
- R_DRAIN to R_WAIT: the last FIFO of the half runs empty.

Each data port is 8 bits wide with a valid/ready handshake. Each domain has its own active-low asynchronous reset. The reset asserts at once and releases synchronously.

Top module: `chunk_fifo_ring`

## Requirements
- R1: After both resets release, in_ready is 1 and out_valid, chunk_ready and overflow are all 0.
- R2: Every byte accepted on the write port leaves the read port exactly once, in the order it was accepted, across any number of trips around the ring.
- R3: chunk_ready stays 0 while fewer than 2048 bytes of the half the reader will take next are stored. It rises once the four FIFOs of that half (FIFOs 0 to 3, then 4 to 7, alternating) are all full.
- R4: While no chunk is ready, out_valid is 0 and out_ready has no effect. The first byte of every 2048-byte chunk is transferred only in a cycle where chunk_ready is 1.
- R5: chunk_ready returns to 0 in the cycle after the first byte of a chunk is taken, and stays 0 while that half drains.
- R6: The writer fills FIFOs in ring order and enters a FIFO only once it is empty. With the reader idle at a chunk boundary, exactly 4096 bytes are accepted, and after that in_ready stays 0.
- R7: overflow is a sticky flag in the write domain. It is set when in_valid is high while the writer is blocked on a full ring. It never rises while in_ready is 1, stays 0 for a producer paced below the reader, and clears only on write reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Producer clock |
| wr_arst_n | input | 1 | Producer-domain asynchronous reset, active low |
| in_valid | input | 1 | Write byte offered |
| in_ready | output | 1 | Write byte accepted this cycle if in_valid |
| in_data | input | 8 | Write byte |
| overflow | output | 1 | Sticky: a byte was offered while the ring was full |
| rd_clk | input | 1 | Consumer clock |
| rd_arst_n | input | 1 | Consumer-domain asynchronous reset, active low |
| out_valid | output | 1 | Read byte available |
| out_ready | input | 1 | Consumer takes the byte when out_valid |
| out_data | output | 8 | Read byte |
| chunk_ready | output | 1 | Next half of the ring is full and may be read |

## Verification
The hardest condition to reach is a ring that is completely full, with the writer blocked, while the reader sits exactly at a chunk boundary. Only in that condition are overflow, the 4096-byte limit and the blocked-to-fill return on drain all visible. The bench reaches it by streaming three whole ring capacities with a paced producer until the reader has consumed every byte. It then stops the reader and pushes bytes at a high rate until the writer stalls. A directed start stops one byte short of the first chunk, probes the read port there, and then supplies the final byte to watch chunk_ready rise.

// File: rtl/cfr_pkg.sv
package cfr_pkg;
    typedef enum logic {W_FILL, W_BLOCKED} wr_state_e;
    typedef enum logic {R_WAIT, R_DRAIN} rd_state_e;
endpackage

// File: rtl/cfr_rst_sync.sv
// Asynchronous assert, two-stage synchronous release.
module cfr_rst_sync (
    input  logic clk,
    input  logic arst_n,
    output logic srst_n
);
    logic [1:0] stg;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) stg <= '0;
        else         stg <= {stg[0], 1'b1};
    end

    assign srst_n = stg[1];
endmodule

// File: rtl/cfr_async_fifo.sv
// Single dual-clock FIFO; Gray pointers crossed through two flops each way.
module cfr_async_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 512
) (
    input  logic              wclk,
    input  logic              wrst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_full,
    output logic              wr_empty,
    input  logic              rclk,
    input  logic              rrst_n,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_full,
    output logic              rd_empty
);
    localparam int AW = $clog2(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW:0] wbin, wgray, wbin_nxt;
    logic [AW:0] rbin, rgray, rbin_nxt;
    logic [AW:0] r2w_q1, r2w_q2, w2r_q1, w2r_q2;

    function automatic logic [AW:0] to_gray(logic [AW:0] b);
        return b ^ (b >> 1);
    endfunction

    // Gray value that is a full lap ahead of g
    function automatic logic [AW:0] lap_of(logic [AW:0] g);
        return {~g[AW:AW-1], g[AW-2:0]};
    endfunction

    // write domain
    assign wbin_nxt = wbin + {{AW{1'b0}}, (wr_en && !wr_full)};

    always_ff @(posedge wclk or negedge wrst_n) begin
        if (!wrst_n) begin
            wbin   <= '0;
            wgray  <= '0;
            r2w_q1 <= '0;
            r2w_q2 <= '0;
        end else begin
            wbin   <= wbin_nxt;
            wgray  <= to_gray(wbin_nxt);
            r2w_q1 <= rgray;
            r2w_q2 <= r2w_q1;
        end
    end

    always_ff @(posedge wclk) begin
        if (wr_en && !wr_full) mem[wbin[AW-1:0]] <= wr_data;
    end

    assign wr_full  = (wgray == lap_of(r2w_q2));
    assign wr_empty = (wgray == r2w_q2);

    // read domain
    assign rbin_nxt = rbin + {{AW{1'b0}}, (rd_en && !rd_empty)};

    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) begin
            rbin   <= '0;
            rgray  <= '0;
            w2r_q1 <= '0;
            w2r_q2 <= '0;
        end else begin
            rbin   <= rbin_nxt;
            rgray  <= to_gray(rbin_nxt);
            w2r_q1 <= wgray;
            w2r_q2 <= w2r_q1;
        end
    end

    assign rd_data  = mem[rbin[AW-1:0]];
    assign rd_full  = (w2r_q2 == lap_of(rgray));
    assign rd_empty = (rgray == w2r_q2);
endmodule

// File: rtl/cfr_wr_ctrl.sv
// Write steering: fills ring slots in order, enters a slot only when empty.
module cfr_wr_ctrl
    import cfr_pkg::*;
#(
    parameter  int SLOTS = 8,
    localparam int SEL_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [SLOTS-1:0] slot_full,
    input  logic [SLOTS-1:0] slot_empty,
    output logic             in_ready,
    output logic [SLOTS-1:0] slot_we,
    output logic             overflow
);
    wr_state_e        state, state_nxt;
    logic [SEL_W-1:0] sel, sel_nxt, sel_inc;

    assign sel_inc = (sel == SEL_W'(SLOTS-1)) ? '0 : sel + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= W_FILL;
            sel   <= '0;
        end else begin
            state <= state_nxt;
            sel   <= sel_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        sel_nxt   = sel;
        unique case (state)
            W_FILL: begin
                if (slot_full[sel]) begin
                    sel_nxt   = sel_inc;
                    state_nxt = slot_empty[sel_inc] ? W_FILL : W_BLOCKED;
                end
            end
            W_BLOCKED: begin
                if (slot_empty[sel]) state_nxt = W_FILL;
            end
        endcase
    end

    always_comb begin
        in_ready = 1'b0;
        slot_we  = '0;
        unique case (state)
            W_FILL: begin
                in_ready     = !slot_full[sel];
                slot_we[sel] = in_valid && !slot_full[sel];
            end
            W_BLOCKED: begin
                in_ready = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               overflow <= 1'b0;
        else if (in_valid && state == W_BLOCKED)  overflow <= 1'b1;
    end
endmodule

// File: rtl/cfr_rd_ctrl.sv
// Read steering: waits for a full half, then drains its slots in order.
module cfr_rd_ctrl
    import cfr_pkg::*;
#(
    parameter  int SLOTS = 8,
    localparam int SEL_W = $clog2(SLOTS),
    localparam int HALF  = SLOTS / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             out_ready,
    input  logic [SLOTS-1:0] slot_full,
    input  logic [SLOTS-1:0] slot_empty,
    output logic             out_valid,
    output logic             chunk_ready,
    output logic [SLOTS-1:0] slot_re,
    output logic [SEL_W-1:0] sel
);
    rd_state_e        state, state_nxt;
    logic [SEL_W-1:0] sel_nxt, sel_inc, base;
    logic             half_full, last_in_half;

    assign base         = (sel >= SEL_W'(HALF)) ? SEL_W'(HALF) : '0;
    assign half_full    = &slot_full[base +: HALF];
    assign last_in_half = (sel == base + SEL_W'(HALF-1));
    assign sel_inc      = (sel == SEL_W'(SLOTS-1)) ? '0 : sel + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= R_WAIT;
            sel   <= '0;
        end else begin
            state <= state_nxt;
            sel   <= sel_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        sel_nxt   = sel;
        unique case (state)
            R_WAIT: begin
                if (half_full && out_ready) state_nxt = R_DRAIN;
            end
            R_DRAIN: begin
                if (slot_empty[sel]) begin
                    sel_nxt = sel_inc;
                    if (last_in_half) state_nxt = R_WAIT;
                end
            end
        endcase
    end

    always_comb begin
        out_valid   = 1'b0;
        chunk_ready = 1'b0;
        unique case (state)
            R_WAIT: begin
                out_valid   = half_full;
                chunk_ready = half_full;
            end
            R_DRAIN: begin
                out_valid = !slot_empty[sel];
            end
        endcase
        slot_re      = '0;
        slot_re[sel] = out_valid && out_ready;
    end
endmodule

// File: rtl/chunk_fifo_ring.sv
module chunk_fifo_ring #(
    parameter int DATA_W     = 8,
    parameter int RING_FIFOS = 8,
    parameter int FIFO_DEPTH = 512
) (
    input  logic              wr_clk,
    input  logic              wr_arst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              overflow,
    input  logic              rd_clk,
    input  logic              rd_arst_n,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              chunk_ready
);
    localparam int SEL_W = $clog2(RING_FIFOS);

    logic                  wr_rst_n, rd_rst_n;
    logic [RING_FIFOS-1:0] w_full, w_empty, r_full, r_empty;
    logic [RING_FIFOS-1:0] slot_we, slot_re;
    logic [SEL_W-1:0]      rsel;
    logic [DATA_W-1:0]     slot_rdata [RING_FIFOS];

    cfr_rst_sync u_wr_rst (.clk(wr_clk), .arst_n(wr_arst_n), .srst_n(wr_rst_n));
    cfr_rst_sync u_rd_rst (.clk(rd_clk), .arst_n(rd_arst_n), .srst_n(rd_rst_n));

    cfr_wr_ctrl #(.SLOTS(RING_FIFOS)) u_wr (
        .clk(wr_clk), .rst_n(wr_rst_n), .in_valid(in_valid),
        .slot_full(w_full), .slot_empty(w_empty),
        .in_ready(in_ready), .slot_we(slot_we), .overflow(overflow)
    );

    cfr_rd_ctrl #(.SLOTS(RING_FIFOS)) u_rd (
        .clk(rd_clk), .rst_n(rd_rst_n), .out_ready(out_ready),
        .slot_full(r_full), .slot_empty(r_empty),
        .out_valid(out_valid), .chunk_ready(chunk_ready),
        .slot_re(slot_re), .sel(rsel)
    );

    for (genvar i = 0; i < RING_FIFOS; i++) begin : g_slot
        cfr_async_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
            .wclk(wr_clk), .wrst_n(wr_rst_n), .wr_en(slot_we[i]), .wr_data(in_data),
            .wr_full(w_full[i]), .wr_empty(w_empty[i]),
            .rclk(rd_clk), .rrst_n(rd_rst_n), .rd_en(slot_re[i]), .rd_data(slot_rdata[i]),
            .rd_full(r_full[i]), .rd_empty(r_empty[i])
        );
    end

    assign out_data = slot_rdata[rsel];
endmodule

// File: rtl/cfr_checks.sv
module cfr_checks #(
    parameter int SLOTS = 8
) (
    input logic             wr_clk,
    input logic             wr_rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             overflow,
    input logic [SLOTS-1:0] w_full,
    input logic [SLOTS-1:0] slot_we,
    input logic             rd_clk,
    input logic             rd_rst_n,
    input logic             out_valid,
    input logic             out_ready,
    input logic             chunk_ready,
    input logic [SLOTS-1:0] slot_re
);
    p_overflow_sticky_r7: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        overflow |=> overflow);

    p_overflow_cause_r7: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        $rose(overflow) |-> $past(in_valid && !in_ready));

    p_single_write_r6: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        $onehot0(slot_we));

    p_write_has_room_r6: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (slot_we & w_full) == '0);

    p_single_read_r2: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        $onehot0(slot_re));

    p_read_needs_handshake_r4: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (|slot_re) |-> (out_valid && out_ready));

    p_chunk_has_data_r4: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        chunk_ready |-> out_valid);

    p_chunk_clears_r5: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (chunk_ready && out_ready) |=> !chunk_ready);
endmodule

bind chunk_fifo_ring cfr_checks #(.SLOTS(RING_FIFOS)) u_checks (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .overflow(overflow), .w_full(w_full), .slot_we(slot_we),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .out_valid(out_valid), .out_ready(out_ready),
    .chunk_ready(chunk_ready), .slot_re(slot_re)
);

// File: tb/sim_chunk_fifo_ring.sv
`timescale 1ns/1ps
module sim_chunk_fifo_ring;
    localparam int RING_BYTES = 4096;
    localparam int CHUNK      = 2048;

    logic       wclk = 1'b0, rclk = 1'b0;
    logic       warst_n = 1'b0, rarst_n = 1'b0;
    logic       in_valid = 1'b0, out_ready = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_ready, overflow, out_valid, chunk_ready;
    logic [7:0] out_data;

    int checks = 0, fails = 0;
    int sent = 0, rcount = 0, target = 0;
    int prod_pct = 40, cons_pct = 85;
    bit cons_en = 1'b0, done = 1'b0;

    always #5      wclk = ~wclk;   // producer, 100 MHz
    always #7.8125 rclk = ~rclk;   // consumer, 64 MHz

    chunk_fifo_ring u0 (
        .wr_clk(wclk), .wr_arst_n(warst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .overflow(overflow),
        .rd_clk(rclk), .rd_arst_n(rarst_n), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .chunk_ready(chunk_ready)
    );

    // Rising byte pattern, shifted per 512-byte block so a lost block shows.
    function automatic logic [7:0] exp_byte(int idx);
        return 8'((idx + (idx >> 9) * 37) & 255);
    endfunction

    task automatic check(string tag, int act, int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Producer: drives and samples on falling edges; ready seen at one falling
    // edge governs the rising edge that follows it.
    initial begin : producer
        bit rq;
        rq = 1'b0;
        forever begin
            @(negedge wclk);
            if (in_valid && rq) begin
                sent++;
                in_valid = 1'b0;
            end
            if (!in_valid && sent < target && $urandom_range(99) < prod_pct) begin
                in_valid = 1'b1;
                in_data  = exp_byte(sent);
            end
            rq = in_ready;
        end
    end

    // Consumer: scoreboard on order, completeness and chunk gating.
    initial begin : consumer
        bit         vq, cq;
        logic [7:0] dq;
        vq = 1'b0; cq = 1'b0; dq = '0;
        forever begin
            @(negedge rclk);
            if (out_ready && vq) begin
                check("R2 byte order", int'(dq), int'(exp_byte(rcount)));
                if (rcount % CHUNK == 0) begin
                    check("R4 chunk start needs chunk_ready", int'(cq), 1);
                    check("R5 chunk_ready clears after first byte", int'(chunk_ready), 0);
                end
                rcount++;
            end
            out_ready = cons_en && ($urandom_range(99) < cons_pct);
            vq = out_valid;
            cq = chunk_ready;
            dq = out_data;
        end
    end

    initial begin : main
        void'($urandom(32'd20240517));
        repeat (4) @(negedge wclk);
        warst_n = 1'b1;
        rarst_n = 1'b1;
        repeat (4) @(negedge rclk);
        check("R1 in_ready after reset", int'(in_ready), 1);
        check("R1 out_valid after reset", int'(out_valid), 0);
        check("R1 chunk_ready after reset", int'(chunk_ready), 0);
        check("R1 overflow after reset", int'(overflow), 0);

        // one byte short of the first chunk
        prod_pct = 70;
        target   = CHUNK - 1;
        wait (sent == CHUNK - 1);
        repeat (40) @(negedge rclk);
        check("R3 chunk_ready low at 2047 bytes", int'(chunk_ready), 0);
        cons_pct = 100;
        cons_en  = 1'b1;
        repeat (30) @(negedge rclk);
        cons_en = 1'b0;
        repeat (2) @(negedge rclk);
        check("R4 reads ignored without chunk", rcount, 0);
        check("R4 out_valid low without chunk", int'(out_valid), 0);

        target = CHUNK;
        wait (sent == CHUNK);
        repeat (10) @(negedge rclk);
        check("R3 chunk_ready at 2048 bytes", int'(chunk_ready), 1);
        check("R4 out_valid with chunk", int'(out_valid), 1);

        // paced streaming over three ring capacities
        prod_pct = 40;
        cons_pct = 85;
        cons_en  = 1'b1;
        target   = 3 * RING_BYTES;
        wait (rcount == 3 * RING_BYTES);
        repeat (10) @(negedge wclk);
        check("R7 no overflow for paced producer", int'(overflow), 0);
        check("R2 stream complete", rcount, sent);

        // fill the whole ring with the reader idle
        cons_en = 1'b0;
        repeat (5) @(negedge rclk);
        prod_pct = 90;
        target   = 4 * RING_BYTES + CHUNK;
        wait (sent == 4 * RING_BYTES);
        repeat (300) @(negedge wclk);
        check("R6 ring holds exactly 4096 bytes", sent, 4 * RING_BYTES);
        check("R6 in_ready low on full ring", int'(in_ready), 0);
        check("R7 overflow set on full ring", int'(overflow), 1);
        check("R3 chunk_ready on full ring", int'(chunk_ready), 1);

        // drain and let the held bytes through
        cons_pct = 85;
        cons_en  = 1'b1;
        wait (rcount == target);
        repeat (10) @(negedge wclk);
        check("R7 overflow stays set", int'(overflow), 1);
        check("R2 all bytes delivered", rcount, 4 * RING_BYTES + CHUNK);
        check("R6 writer resumed after drain", sent, 4 * RING_BYTES + CHUNK);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : watchdog
        #1800000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R2 watchdog: actual rcount=%0d expected=%0d", rcount, target);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule